// File: doc/BRIEF.md
# Converter Event Status Register

This block holds the event flags of a data-converter controller as one 32-bit register on a simple memory-mapped bus. Six flags record that something happened in the converter: a regular conversion began, an injected group began, a regular conversion or sequence finished, the injected group finished, a converted value left the programmed threshold window, or data were lost. Each flag is raised by a one-cycle hardware pulse. It stays raised until software removes it.

Software clears flags by writing a full word with a 0 in each bit it wants cleared. Bits written with a 1 keep their value, so a read-modify-write cannot lose an event that arrives between the read and the write. The regular end-of-conversion flag is also cleared when the converted-data register is read. The overrun flag can only be raised in the modes where the data path actually fills a result register faster than it is drained. The registered flags drive an interrupt request through per-flag enables.

Top module: `cnv_stat_reg`

## Requirements
- R1: After reset every flag is 0, the interrupt request is 0 and a read of the register returns 0.
- R2: A read at the register offset (0x0) returns window flag in bit 0, regular end-of-conversion in bit 1, injected end-of-conversion in bit 2, injected start in bit 3, regular start in bit 4 and overrun in bit 5. Bits 31:6 read 0. Bytes whose byte enable is 0 read 0, and reads at any other offset return 0.
- R3: A pulse on a start, window or injected-group event input sets its flag on the next clock edge, and the flag then holds until it is cleared.
- R4: A write at offset 0x0 with all four byte enables set clears each flag whose write-data bit is 0 and leaves each flag whose write-data bit is 1 unchanged.
- R5: A write with any byte enable at 0 leaves every flag unchanged. The output `wr_full` is 1 during a write access exactly when all byte enables are 1.
- R6: A pulse on `dr_rd` clears the regular end-of-conversion flag (bit 1) and no other flag.
- R7: An overrun pulse sets bit 5 only while `mode_dma` or `mode_eoc_seq` is 1; with both at 0 the pulse is ignored.
- R8: With `mode_eoc_seq` at 0, bit 1 is set by `evt_conv_done` and `evt_seq_done` is ignored. With `mode_eoc_seq` at 1, bit 1 is set by `evt_seq_done` and `evt_conv_done` is ignored.
- R9: Bit 2 is set only by `evt_inj_grp_done`, the end of the whole injected group.
- R10: When a set event and a clear (a zero written to the bit, or `dr_rd` for bit 1) hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is 1 exactly when at least one flag is set whose bit in `irq_en` (same bit positions as R2) is 1.
- R12: A write at any offset other than 0x0 leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| wr_full | output | 1 | Current write access is a full word |
| evt_reg_start | input | 1 | Regular conversion started |
| evt_inj_start | input | 1 | Injected group started |
| evt_conv_done | input | 1 | One regular conversion finished |
| evt_seq_done | input | 1 | Regular sequence finished |
| evt_inj_grp_done | input | 1 | All injected channels converted |
| evt_window | input | 1 | Converted value outside threshold window |
| evt_overrun | input | 1 | Converted data lost |
| mode_dma | input | 1 | DMA mode enabled |
| mode_eoc_seq | input | 1 | End-of-conversion reported per sequence |
| dr_rd | input | 1 | Converted-data register read strobe |
| irq_en | input | 6 | Per-flag interrupt enables |
| stat_flags | output | 6 | Registered flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a clear and a set landing on the same flag in one cycle. The bench drives the event pulse and the zero-write, or the data-register strobe, in the same half-cycle window so that both act at one edge. It then checks that the flag survives. It also sweeps all 64 clear patterns over a fully set register and all 15 partial byte-enable patterns. Expected contents come from a bit-mask computation in the bench.

// File: rtl/cnv_stat_pkg.sv
// Shared constants for the converter status register.
// Assumes the bit positions below are the software-visible layout.
package cnv_stat_pkg;
    localparam int unsigned NFLAG     = 6;
    localparam int unsigned B_WINDOW  = 0;
    localparam int unsigned B_REG_EOC = 1;
    localparam int unsigned B_INJ_EOC = 2;
    localparam int unsigned B_INJ_STA = 3;
    localparam int unsigned B_REG_STA = 4;
    localparam int unsigned B_OVR     = 5;
    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/cnv_stat_bus_dec.sv
// Decodes a bus access into a full-word write hit, a read hit and a byte mask.
// Assumes one access per cycle and that bus_addr is a byte offset.
module cnv_stat_bus_dec #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned REG_OFS = 0,
    localparam int unsigned BE_W   = DATA_W / 8
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output logic              wr_full,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic [DATA_W-1:0] byte_mask
);
    logic ofs_match;

    // Compare the access offset with the register offset.
    always_comb begin
        ofs_match = (addr == ADDR_W'(REG_OFS));
    end

    // Classify the access: full-word write, register write hit, register read.
    always_comb begin
        wr_full = sel && we && (&be);
        wr_hit  = wr_full && ofs_match;
        rd_hit  = sel && !we && ofs_match;
    end

    // Expand byte enables into a bit mask for read data.
    for (genvar g = 0; g < BE_W; g++) begin : g_mask
        assign byte_mask[g*8 +: 8] = {8{be[g]}};
    end
endmodule

// File: rtl/cnv_stat_evt_map.sv
// Maps hardware event pulses onto per-flag set requests.
// Applies overrun gating and end-of-conversion source selection.
module cnv_stat_evt_map
    import cnv_stat_pkg::*;
(
    input  logic      evt_reg_start,
    input  logic      evt_inj_start,
    input  logic      evt_conv_done,
    input  logic      evt_seq_done,
    input  logic      evt_inj_grp_done,
    input  logic      evt_window,
    input  logic      evt_overrun,
    input  logic      mode_dma,
    input  logic      mode_eoc_seq,
    output flag_vec_t set_req
);
    logic ovr_armed;
    logic eoc_src;

    // Overrun detection runs only in DMA or per-sequence mode.
    always_comb begin
        ovr_armed = mode_dma || mode_eoc_seq;
    end

    // Pick the end-of-conversion source by mode.
    always_comb begin
        eoc_src = mode_eoc_seq ? evt_seq_done : evt_conv_done;
    end

    // Assemble the set vector in register bit order.
    always_comb begin
        set_req            = '0;
        set_req[B_WINDOW]  = evt_window;
        set_req[B_REG_EOC] = eoc_src;
        set_req[B_INJ_EOC] = evt_inj_grp_done;
        set_req[B_INJ_STA] = evt_inj_start;
        set_req[B_REG_STA] = evt_reg_start;
        set_req[B_OVR]     = evt_overrun && ovr_armed;
    end
endmodule

// File: rtl/cnv_stat_flag_cell.sv
// One sticky status flag: set by hardware, cleared by request; set wins.
// Assumes set and clear are single-cycle qualified pulses.
module cnv_stat_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag; a same-cycle set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/cnv_stat_irq.sv
// Combines registered flags with per-flag enables into one request.
// Assumes flags come straight from registers, so irq is glitch-free per cycle.
module cnv_stat_irq
    import cnv_stat_pkg::*;
(
    input  flag_vec_t flags,
    input  flag_vec_t en,
    output logic      irq
);
    // Request when any enabled flag is raised.
    always_comb begin
        irq = |(flags & en);
    end
endmodule

// File: rtl/cnv_stat_reg.sv
// Converter status register: six sticky event flags, write-zero-to-clear,
// data-read clear of the regular end-of-conversion flag, gated overrun,
// interrupt request. Assumes a single-cycle, zero-wait bus.
module cnv_stat_reg
    import cnv_stat_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned REG_OFS = 0,
    localparam int unsigned BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wr_full,
    input  logic              evt_reg_start,
    input  logic              evt_inj_start,
    input  logic              evt_conv_done,
    input  logic              evt_seq_done,
    input  logic              evt_inj_grp_done,
    input  logic              evt_window,
    input  logic              evt_overrun,
    input  logic              mode_dma,
    input  logic              mode_eoc_seq,
    input  logic              dr_rd,
    input  logic [NFLAG-1:0]  irq_en,
    output logic [NFLAG-1:0]  stat_flags,
    output logic              irq
);
    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] byte_mask;
    flag_vec_t         set_req;
    flag_vec_t         clr_req;
    flag_vec_t         flag_q;
    logic              unused_wdata_hi;

    cnv_stat_bus_dec #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REG_OFS(REG_OFS)
    ) u_dec (
        .sel      (bus_sel),
        .we       (bus_we),
        .addr     (bus_addr),
        .be       (bus_be),
        .wr_full  (wr_full),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit),
        .byte_mask(byte_mask)
    );

    cnv_stat_evt_map u_map (
        .evt_reg_start   (evt_reg_start),
        .evt_inj_start   (evt_inj_start),
        .evt_conv_done   (evt_conv_done),
        .evt_seq_done    (evt_seq_done),
        .evt_inj_grp_done(evt_inj_grp_done),
        .evt_window      (evt_window),
        .evt_overrun     (evt_overrun),
        .mode_dma        (mode_dma),
        .mode_eoc_seq    (mode_eoc_seq),
        .set_req         (set_req)
    );

    // Reserved write bits carry no meaning.
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NFLAG];

    // Build clear requests: zero-written bits, plus data-read for regular EOC.
    always_comb begin
        clr_req = wr_hit ? ~bus_wdata[NFLAG-1:0] : '0;
        clr_req[B_REG_EOC] = clr_req[B_REG_EOC] || dr_rd;
    end

    // One sticky cell per flag.
    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        cnv_stat_flag_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (set_req[f]),
            .clr  (clr_req[f]),
            .q    (flag_q[f])
        );
    end

    cnv_stat_irq u_irq (
        .flags(flag_q),
        .en   (irq_en),
        .irq  (irq)
    );

    // Present flags; reserved bits, unselected bytes and other offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata = {{(DATA_W-NFLAG){1'b0}}, flag_q} & byte_mask;
        end
    end

    assign stat_flags = flag_q;
endmodule

// File: rtl/cnv_stat_chk.sv
// Property checker for cnv_stat_reg, attached with bind.
module cnv_stat_chk
    import cnv_stat_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned REG_OFS = 0,
    localparam int unsigned BE_W   = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              evt_reg_start,
    input logic              evt_inj_start,
    input logic              evt_conv_done,
    input logic              evt_seq_done,
    input logic              evt_inj_grp_done,
    input logic              evt_window,
    input logic              evt_overrun,
    input logic              mode_dma,
    input logic              mode_eoc_seq,
    input logic              dr_rd,
    input logic [NFLAG-1:0]  irq_en,
    input logic [NFLAG-1:0]  stat_flags,
    input logic              irq
);
    logic any_evt;
    assign any_evt = evt_reg_start | evt_inj_start | evt_conv_done | evt_seq_done
                   | evt_inj_grp_done | evt_window | evt_overrun;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NFLAG] == '0);

    a_r3_inj_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_inj_start |=> stat_flags[B_INJ_STA]);

    a_r4_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && (&bus_be) && bus_addr == ADDR_W'(REG_OFS)
         && (&bus_wdata[NFLAG-1:0]) && !dr_rd)
        |=> (($past(stat_flags) & ~stat_flags) == '0));

    a_r5_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !(&bus_be) && !any_evt && !dr_rd)
        |=> $stable(stat_flags));

    a_r6_dr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_rd && !evt_conv_done && !evt_seq_done) |=> !stat_flags[B_REG_EOC]);

    a_r7_ovr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dma && !mode_eoc_seq && !stat_flags[B_OVR]) |=> !stat_flags[B_OVR]);

    a_r10_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_rd && evt_conv_done && !mode_eoc_seq) |=> stat_flags[B_REG_EOC]);

    a_r11_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
endmodule

bind cnv_stat_reg cnv_stat_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_OFS(REG_OFS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_sel         (bus_sel),
    .bus_we          (bus_we),
    .bus_addr        (bus_addr),
    .bus_be          (bus_be),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .evt_reg_start   (evt_reg_start),
    .evt_inj_start   (evt_inj_start),
    .evt_conv_done   (evt_conv_done),
    .evt_seq_done    (evt_seq_done),
    .evt_inj_grp_done(evt_inj_grp_done),
    .evt_window      (evt_window),
    .evt_overrun     (evt_overrun),
    .mode_dma        (mode_dma),
    .mode_eoc_seq    (mode_eoc_seq),
    .dr_rd           (dr_rd),
    .irq_en          (irq_en),
    .stat_flags      (stat_flags),
    .irq             (irq)
);

// File: tb/tb_cnv_stat_reg.sv
module tb_cnv_stat_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [3:0]  bus_be = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        wr_full;
    logic        evt_reg_start = 0, evt_inj_start = 0, evt_conv_done = 0, evt_seq_done = 0;
    logic        evt_inj_grp_done = 0, evt_window = 0, evt_overrun = 0;
    logic        mode_dma = 0, mode_eoc_seq = 0, dr_rd = 0;
    logic [5:0]  irq_en = 0;
    logic [5:0]  stat_flags;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cnv_stat_reg dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_full(wr_full),
        .evt_reg_start(evt_reg_start), .evt_inj_start(evt_inj_start),
        .evt_conv_done(evt_conv_done), .evt_seq_done(evt_seq_done),
        .evt_inj_grp_done(evt_inj_grp_done), .evt_window(evt_window),
        .evt_overrun(evt_overrun), .mode_dma(mode_dma), .mode_eoc_seq(mode_eoc_seq),
        .dr_rd(dr_rd), .irq_en(irq_en), .stat_flags(stat_flags), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a full or partial write for one clock; returns at the next negedge.
    task automatic do_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        #1 chk("R5 wr_full", {31'd0, wr_full}, {31'd0, be == 4'hF});
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_be = 0; bus_wdata = 0;
    endtask

    task automatic do_read(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_be = 0;
    endtask

    // Pulse a set of events (bit order: window, conv, inj grp, inj start, reg start, ovr, seq).
    task automatic pulse(input logic [6:0] e);
        {evt_seq_done, evt_overrun, evt_reg_start, evt_inj_start,
         evt_inj_grp_done, evt_conv_done, evt_window} = e;
        @(negedge clk);
        {evt_seq_done, evt_overrun, evt_reg_start, evt_inj_start,
         evt_inj_grp_done, evt_conv_done, evt_window} = '0;
    endtask

    task automatic set_all();
        mode_dma = 1; mode_eoc_seq = 0;
        pulse(7'h3F);
        mode_dma = 0;
    endtask

    task automatic clear_all();
        do_write(4'h0, 4'hF, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flags", {26'd0, stat_flags}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        do_read(4'h0, 4'hF, rd);
        chk("R1 read", rd, 32'd0);

        // R3/R2: each single event sets exactly its bit, read back in place
        begin
            logic [6:0] ev [5];
            int bitpos [5];
            ev[0] = 7'h01; bitpos[0] = 0;
            ev[1] = 7'h04; bitpos[1] = 2;
            ev[2] = 7'h08; bitpos[2] = 3;
            ev[3] = 7'h10; bitpos[3] = 4;
            ev[4] = 7'h02; bitpos[4] = 1;
            for (int i = 0; i < 5; i++) begin
                pulse(ev[i]);
                @(negedge clk);
                chk("R3 held", {26'd0, stat_flags}, 32'd1 << bitpos[i]);
                do_read(4'h0, 4'hF, rd);
                chk("R2 layout", rd, 32'd1 << bitpos[i]);
                clear_all();
            end
        end
        // R9 injected group done sets only bit 2
        pulse(7'h04);
        chk("R9 inj eoc", {26'd0, stat_flags}, 32'h4);
        clear_all();

        // R4 sweep of all 64 clear patterns, reserved bits noisy
        for (int p = 0; p < 64; p++) begin
            set_all();
            do_write(4'h0, 4'hF, {26'h2AAAAAA ^ 26'(p * 977), 6'(p)});
            chk("R4 clear pattern", {26'd0, stat_flags}, 32'(p));
            clear_all();
        end

        // R5 all partial byte-enable patterns ignored
        set_all();
        for (int b = 0; b < 15; b++) begin
            do_write(4'h0, 4'(b), 32'h0);
            chk("R5 partial", {26'd0, stat_flags}, 32'h3F);
        end
        // R12 write to other offsets ignored, reads there return zero
        for (int a = 1; a < 16; a++) begin
            do_write(4'(a), 4'hF, 32'h0);
            chk("R12 other ofs", {26'd0, stat_flags}, 32'h3F);
            do_read(4'(a), 4'hF, rd);
            chk("R2 other ofs read", rd, 32'd0);
        end
        // R2 byte enable masking on reads
        do_read(4'h0, 4'h1, rd);
        chk("R2 byte0", rd, 32'h3F);
        do_read(4'h0, 4'hE, rd);
        chk("R2 upper bytes", rd, 32'h0);

        // R6 data read clears only bit 1
        dr_rd = 1; @(negedge clk); dr_rd = 0;
        chk("R6 dr clear", {26'd0, stat_flags}, 32'h3D);

        // R11 irq across all enable patterns with flags 0x3D
        for (int e = 0; e < 64; e++) begin
            irq_en = 6'(e);
            #1 chk("R11 irq", {31'd0, irq}, {31'd0, (e & 'h3D) != 0});
            @(negedge clk);
        end
        irq_en = 0;
        clear_all();

        // R7 overrun gating over all mode combinations
        for (int m = 0; m < 4; m++) begin
            {mode_dma, mode_eoc_seq} = 2'(m);
            pulse(7'h20);
            chk("R7 ovr gate", {26'd0, stat_flags}, (m != 0) ? 32'h20 : 32'h0);
            clear_all();
        end

        // R8 end-of-conversion source selection
        for (int s = 0; s < 2; s++) begin
            mode_dma = 0; mode_eoc_seq = s[0];
            pulse(7'h02);
            chk("R8 conv done", {26'd0, stat_flags}, (s == 0) ? 32'h2 : 32'h0);
            clear_all();
            pulse(7'h40);
            chk("R8 seq done", {26'd0, stat_flags}, (s == 1) ? 32'h2 : 32'h0);
            clear_all();
        end
        mode_eoc_seq = 0;

        // R10 set beats clear: zero-write with every event in same cycle
        mode_dma = 1;
        bus_sel = 1; bus_we = 1; bus_addr = 0; bus_be = 4'hF; bus_wdata = 0;
        {evt_overrun, evt_reg_start, evt_inj_start, evt_inj_grp_done,
         evt_conv_done, evt_window} = 6'h3F;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_be = 0;
        {evt_overrun, evt_reg_start, evt_inj_start, evt_inj_grp_done,
         evt_conv_done, evt_window} = 6'h0;
        mode_dma = 0;
        chk("R10 write vs set", {26'd0, stat_flags}, 32'h3F);
        // R10 data read and new conversion in same cycle
        dr_rd = 1; evt_conv_done = 1;
        @(negedge clk);
        dr_rd = 0; evt_conv_done = 0;
        chk("R10 dr vs set", {26'd0, stat_flags}, 32'h3F);
        clear_all();
        chk("R4 final clear", {26'd0, stat_flags}, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule